// File: doc/BRIEF.md
# Serial Port Control Register Sequencer

This block is the processor-side register front end of an asynchronous serial port. A processor reaches it over an 8-bit bus with one select, one read strobe, one write strobe and a single address bit that picks between the data location and the control/status location. Control writes are steered by a small sequencer. Right after reset, or after a software reset command, the next control write is latched as the line-format (mode) byte. Every control write after that is decoded as a command byte.

The block keeps the latched line format and drives it to the serial engines: stop-bit code, parity enable and sense, word length and clock divisor. It also keeps the command bits that enable the transmitter and receiver, hold a break on the line, and drive the two modem-control outputs. It keeps sticky parity, overrun and framing error flags, which are set by one-cycle pulses from the receiver and cleared by a command. It builds the status byte from those flags and from live levels reported by the engines and the modem input. Accesses to the data location are passed through as a load strobe to the transmitter and a take strobe to the receiver. The serial bit engines themselves are separate blocks.

Top module: `ser_ctl_front`

## Requirements
- R1: After hardware reset the block expects a mode byte, all command outputs (rts_o, dtr_o, tx_en_o, rx_en_o, tx_brk_o) are 0, all error flags are 0, and the line format reads word_len_o=3 (8 bits), stop_sel_o=1, par_en_o=0, par_even_o=0, clk_div_o=1.
- R2: A control write (sel_i=1, wr_i=1, addr_ctl_i=1) made while a mode byte is expected is latched as the mode byte: bits [7:6] go to stop_sel_o, bit 5 to par_even_o, bit 4 to par_en_o, bits [3:2] to word_len_o and bits [1:0] to clk_div_o. The outputs change at the clock edge of the write. Every later control write is a command byte.
- R3: A command byte sets rts_o from bit 5, tx_brk_o from bit 3, rx_en_o from bit 2, dtr_o from bit 1 and tx_en_o from bit 0. Bit 7 is ignored. A command byte never changes the line-format outputs.
- R4: A command byte with bit 6 set returns the block to expecting a mode byte and clears every command output. All other bits of that byte are discarded, including bit 4.
- R5: A command byte with bit 4 set (and bit 6 clear) clears the parity, overrun and framing error flags. An error pulse arriving in the same cycle as that command wins, so its flag ends up set.
- R6: A one-cycle pulse on rx_par_err_i, rx_ovr_err_i or rx_frm_err_i sets its flag, and the flag stays set until R5 or a hardware reset clears it.
- R7: A read of the control location returns the status byte: bit 7 DSR, bit 6 rx_brk_i, bit 5 framing error, bit 4 overrun error, bit 3 parity error, bit 2 tx_empty_i, bit 1 rx_ready_i, bit 0 tx_ready_i.
- R8: Status bit 7 reads 1 when dsr_n_i is low and 0 when it is high.
- R9: Mode code 00 in bits [1:0] is latched as 01 (1x clock), and code 00 in bits [7:6] is latched as 01 (one stop bit). stop_sel_o and clk_div_o therefore never read 0.
- R10: A data write pulses tx_load_o with tx_data_o equal to the written byte. A data read returns rx_data_i and pulses rx_take_o. Neither access changes the control state. With sel_i low, rdata_o reads 0 and no write has any effect.
- R11: Mode byte 0x4E followed by command byte 0x37 gives 8 data bits, no parity, stop code 1 and clock code 2 (16x). It also sets tx_en_o, rx_en_o, dtr_o and rts_o to 1, leaves tx_brk_o at 0, and clears all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_ctl_i | input | 1 | 1 = control/status location, 0 = data location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| tx_load_o | output | 1 | Data-write strobe to the transmitter |
| tx_data_o | output | 8 | Byte handed to the transmitter |
| rx_take_o | output | 1 | Data-read strobe to the receiver |
| rx_data_i | input | 8 | Received byte from the receiver |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| tx_empty_i | input | 1 | Transmitter has nothing left to send |
| rx_ready_i | input | 1 | Receiver holds an unread byte |
| rx_brk_i | input | 1 | Receiver break-detect level |
| rx_par_err_i | input | 1 | Parity error pulse |
| rx_ovr_err_i | input | 1 | Overrun error pulse |
| rx_frm_err_i | input | 1 | Framing error pulse |
| dsr_n_i | input | 1 | Modem data-set-ready pin, active low |
| rts_o | output | 1 | Request-to-send, 1 = asserted |
| dtr_o | output | 1 | Data-terminal-ready, 1 = asserted |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| tx_brk_o | output | 1 | Hold the line in break |
| stop_sel_o | output | 2 | Stop code: 1 = one, 2 = one and a half, 3 = two |
| par_en_o | output | 1 | Parity enable |
| par_even_o | output | 1 | 1 = even parity, 0 = odd |
| word_len_o | output | 2 | Data bits minus 5 |
| clk_div_o | output | 2 | Clock code: 1 = 1x, 2 = 16x, 3 = 64x |

## Verification
The sequencer is exercised with the standard initialisation pair, with a bare software-reset byte, and with a software-reset byte that has every other bit set. Together these show whether the mode/command decision follows the sequencer state, and whether the other bits of a reset byte leak into the command register. Mode bytes with all-zero codes and with every field set show whether the fields are in the right positions and whether codes are normalised. Error pulses given alone, held over idle cycles, cleared with and without the error-reset bit, and raced against the clear in the same cycle show stickiness and update order. Data-location accesses and deselected writes of a software-reset byte show that they leave the control state alone.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    localparam int BUS_W = 8;

    // command byte bit positions
    localparam int CMD_IRST = 6;
    localparam int CMD_RTS  = 5;
    localparam int CMD_ERST = 4;
    localparam int CMD_BRK  = 3;
    localparam int CMD_RXEN = 2;
    localparam int CMD_DTR  = 1;
    localparam int CMD_TXEN = 0;

    // mode byte, packed in bus bit order (msb first)
    typedef struct packed {
        logic [1:0] stop;
        logic       even;
        logic       par_en;
        logic [1:0] wlen;
        logic [1:0] div;
    } line_fmt_t;

    typedef struct packed {
        logic rts;
        logic brk;
        logic rx_en;
        logic dtr;
        logic tx_en;
    } cmd_bits_t;

    typedef struct packed {
        logic pe;
        logic oe;
        logic fe;
    } err_flags_t;

    localparam line_fmt_t FMT_RST = '{stop: 2'b01, even: 1'b0, par_en: 1'b0,
                                      wlen: 2'b11, div: 2'b01};

endpackage

// File: rtl/ser_ctl_seq.sv
module ser_ctl_seq
    import ser_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             mode_wait,
    output line_fmt_t        fmt,
    output cmd_bits_t        cmd,
    output logic             err_clr
);

    typedef struct packed {
        logic      mode_wait;
        line_fmt_t fmt;
        cmd_bits_t cmd;
    } seq_st_t;

    seq_st_t   s_d, s_q;
    line_fmt_t new_fmt;

    always_comb begin
        s_d     = s_q;
        err_clr = 1'b0;
        new_fmt = line_fmt_t'(wdata);
        if (new_fmt.stop == 2'b00) new_fmt.stop = 2'b01;
        if (new_fmt.div == 2'b00)  new_fmt.div  = 2'b01;
        if (ctl_wr) begin
            if (s_q.mode_wait) begin
                s_d.fmt       = new_fmt;
                s_d.mode_wait = 1'b0;
            end else if (wdata[CMD_IRST]) begin
                s_d.mode_wait = 1'b1;
                s_d.cmd       = '0;
            end else begin
                s_d.cmd.rts   = wdata[CMD_RTS];
                s_d.cmd.brk   = wdata[CMD_BRK];
                s_d.cmd.rx_en = wdata[CMD_RXEN];
                s_d.cmd.dtr   = wdata[CMD_DTR];
                s_d.cmd.tx_en = wdata[CMD_TXEN];
                err_clr       = wdata[CMD_ERST];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode_wait <= 1'b1;
            s_q.fmt       <= FMT_RST;
            s_q.cmd       <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_wait = s_q.mode_wait;
    assign fmt       = s_q.fmt;
    assign cmd       = s_q.cmd;

endmodule

// File: rtl/ser_ctl_errs.sv
module ser_ctl_errs
    import ser_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  err_flags_t set,
    input  logic       clr,
    output err_flags_t flags
);

    err_flags_t f_d, f_q;

    // a set in the clearing cycle wins
    always_comb begin
        f_d = clr ? '0 : f_q;
        f_d = f_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

endmodule

// File: rtl/ser_ctl_rdmux.sv
module ser_ctl_rdmux
    import ser_ctl_pkg::*;
(
    input  logic             rd_en,
    input  logic             addr_ctl,
    input  logic [BUS_W-1:0] rx_data,
    input  logic             dsr_n,
    input  logic             brk_det,
    input  err_flags_t       errs,
    input  logic             tx_empty,
    input  logic             rx_ready,
    input  logic             tx_ready,
    output logic [BUS_W-1:0] rdata
);

    logic [BUS_W-1:0] status;

    always_comb begin
        status = {~dsr_n, brk_det, errs.fe, errs.oe, errs.pe,
                  tx_empty, rx_ready, tx_ready};
        if (!rd_en)        rdata = '0;
        else if (addr_ctl) rdata = status;
        else               rdata = rx_data;
    end

endmodule

// File: rtl/ser_ctl_front.sv
module ser_ctl_front
    import ser_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic       addr_ctl_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       tx_load_o,
    output logic [7:0] tx_data_o,
    output logic       rx_take_o,
    input  logic [7:0] rx_data_i,
    input  logic       tx_ready_i,
    input  logic       tx_empty_i,
    input  logic       rx_ready_i,
    input  logic       rx_brk_i,
    input  logic       rx_par_err_i,
    input  logic       rx_ovr_err_i,
    input  logic       rx_frm_err_i,
    input  logic       dsr_n_i,
    output logic       rts_o,
    output logic       dtr_o,
    output logic       tx_en_o,
    output logic       rx_en_o,
    output logic       tx_brk_o,
    output logic [1:0] stop_sel_o,
    output logic       par_en_o,
    output logic       par_even_o,
    output logic [1:0] word_len_o,
    output logic [1:0] clk_div_o
);

    logic       ctl_wr, rd_en, err_clr, mode_wait;
    line_fmt_t  fmt;
    cmd_bits_t  cmd;
    err_flags_t err_set, err_flags;

    assign ctl_wr  = sel_i & wr_i & addr_ctl_i;
    assign rd_en   = sel_i & rd_i;
    assign err_set = '{pe: rx_par_err_i, oe: rx_ovr_err_i, fe: rx_frm_err_i};

    ser_ctl_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .wdata     (wdata_i),
        .mode_wait (mode_wait),
        .fmt       (fmt),
        .cmd       (cmd),
        .err_clr   (err_clr)
    );

    ser_ctl_errs u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (err_clr),
        .flags (err_flags)
    );

    ser_ctl_rdmux u_rdmux (
        .rd_en    (rd_en),
        .addr_ctl (addr_ctl_i),
        .rx_data  (rx_data_i),
        .dsr_n    (dsr_n_i),
        .brk_det  (rx_brk_i),
        .errs     (err_flags),
        .tx_empty (tx_empty_i),
        .rx_ready (rx_ready_i),
        .tx_ready (tx_ready_i),
        .rdata    (rdata_o)
    );

    assign tx_load_o  = sel_i & wr_i & ~addr_ctl_i;
    assign tx_data_o  = wdata_i;
    assign rx_take_o  = rd_en & ~addr_ctl_i;

    assign rts_o      = cmd.rts;
    assign dtr_o      = cmd.dtr;
    assign tx_en_o    = cmd.tx_en;
    assign rx_en_o    = cmd.rx_en;
    assign tx_brk_o   = cmd.brk;
    assign stop_sel_o = fmt.stop;
    assign par_en_o   = fmt.par_en;
    assign par_even_o = fmt.even;
    assign word_len_o = fmt.wlen;
    assign clk_div_o  = fmt.div;

endmodule

// File: rtl/ser_ctl_chk.sv
module ser_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_i,
    input logic       rd_i,
    input logic       wr_i,
    input logic       addr_ctl_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic       dsr_n_i,
    input logic       rx_par_err_i,
    input logic       rx_ovr_err_i,
    input logic       rx_frm_err_i,
    input logic       mode_wait,
    input logic [2:0] err_flags,
    input logic       rts_o,
    input logic       dtr_o,
    input logic       tx_en_o,
    input logic       rx_en_o,
    input logic       tx_brk_o,
    input logic [1:0] stop_sel_o,
    input logic [1:0] word_len_o,
    input logic [1:0] clk_div_o,
    input logic       par_en_o,
    input logic       par_even_o
);

    logic ctl_wr, cmd_wr, no_err_in;
    assign ctl_wr    = sel_i && wr_i && addr_ctl_i;
    assign cmd_wr    = ctl_wr && !mode_wait;
    assign no_err_in = !rx_par_err_i && !rx_ovr_err_i && !rx_frm_err_i;

    // R2
    mode_then_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && mode_wait |=> !mode_wait);

    // R4
    irst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata_i[6] |=> mode_wait && !rts_o && !dtr_o && !tx_en_o
                                 && !rx_en_o && !tx_brk_o);

    // R3
    modem_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !wdata_i[6] |=> rts_o == $past(wdata_i[5])
                                  && dtr_o == $past(wdata_i[1]));

    // R3
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && mode_wait) |=> $stable(word_len_o) && $stable(stop_sel_o)
            && $stable(clk_div_o) && $stable(par_en_o) && $stable(par_even_o));

    // R9
    codes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_sel_o != 2'b00 && clk_div_o != 2'b00);

    // R5
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !wdata_i[6] && wdata_i[4] && no_err_in |=> err_flags == 3'b000);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[2] && !(cmd_wr && wdata_i[4] && !wdata_i[6]) |=> err_flags[2]);

    // R8
    dsr_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && rd_i && addr_ctl_i |-> rdata_o[7] == !dsr_n_i);

    // R10
    data_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && wr_i && !addr_ctl_i |=> $stable(mode_wait) && $stable(rts_o)
                                          && $stable(rx_en_o));

endmodule

bind ser_ctl_front ser_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel_i),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .addr_ctl_i   (addr_ctl_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .dsr_n_i      (dsr_n_i),
    .rx_par_err_i (rx_par_err_i),
    .rx_ovr_err_i (rx_ovr_err_i),
    .rx_frm_err_i (rx_frm_err_i),
    .mode_wait    (mode_wait),
    .err_flags    (err_flags),
    .rts_o        (rts_o),
    .dtr_o        (dtr_o),
    .tx_en_o      (tx_en_o),
    .rx_en_o      (rx_en_o),
    .tx_brk_o     (tx_brk_o),
    .stop_sel_o   (stop_sel_o),
    .word_len_o   (word_len_o),
    .clk_div_o    (clk_div_o),
    .par_en_o     (par_en_o),
    .par_even_o   (par_even_o)
);

// File: tb/ser_ctl_front_bench.sv
`timescale 1ns/1ps
module ser_ctl_front_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_i = 0, rd_i = 0, wr_i = 0, addr_ctl_i = 0;
    logic [7:0] wdata_i = '0, rx_data_i = '0;
    logic       tx_ready_i = 1, tx_empty_i = 1, rx_ready_i = 0, rx_brk_i = 0;
    logic       rx_par_err_i = 0, rx_ovr_err_i = 0, rx_frm_err_i = 0;
    logic       dsr_n_i = 1;
    logic [7:0] rdata_o, tx_data_o;
    logic       tx_load_o, rx_take_o;
    logic       rts_o, dtr_o, tx_en_o, rx_en_o, tx_brk_o, par_en_o, par_even_o;
    logic [1:0] stop_sel_o, word_len_o, clk_div_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ser_ctl_front u_ser_ctl_front (.*);

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // {rts,dtr,tx_en,rx_en,brk}
    function automatic logic [7:0] cmd_out();
        return {3'b0, rts_o, dtr_o, tx_en_o, rx_en_o, tx_brk_o};
    endfunction

    // stop,even,pen,wlen,div in mode byte order
    function automatic logic [7:0] fmt_out();
        return {stop_sel_o, par_even_o, par_en_o, word_len_o, clk_div_o};
    endfunction

    task automatic bus_wr(logic ctl, logic [7:0] b);
        @(negedge clk);
        sel_i = 1; wr_i = 1; addr_ctl_i = ctl; wdata_i = b;
        @(negedge clk);
        sel_i = 0; wr_i = 0;
    endtask

    task automatic bus_rd(logic ctl, output logic [7:0] v, output logic take);
        @(negedge clk);
        sel_i = 1; rd_i = 1; addr_ctl_i = ctl;
        #1 v = rdata_o; take = rx_take_o;
        @(negedge clk);
        sel_i = 0; rd_i = 0;
    endtask

    task automatic err_pulse(logic p, logic o, logic f);
        @(negedge clk);
        rx_par_err_i = p; rx_ovr_err_i = o; rx_frm_err_i = f;
        @(negedge clk);
        rx_par_err_i = 0; rx_ovr_err_i = 0; rx_frm_err_i = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v; logic tk;
        check("R1 command outputs", cmd_out(), 8'h00);
        check("R1 line format", fmt_out(), 8'h4D);
        bus_rd(1, v, tk);
        check("R1 R7 status after reset", v, 8'h05);
    endtask

    task automatic t_init();
        logic [7:0] v; logic tk;
        err_pulse(1, 1, 1);
        bus_wr(1, 8'h4E);
        check("R11 R2 mode 4E fields", fmt_out(), 8'h4E);
        check("R2 mode byte sets no command", cmd_out(), 8'h00);
        bus_wr(1, 8'h37);
        check("R11 command 37 outputs", cmd_out(), 8'h1E);
        check("R11 mode kept", fmt_out(), 8'h4E);
        bus_rd(1, v, tk);
        check("R11 R5 errors cleared", v & 8'h38, 8'h00);
    endtask

    task automatic t_cmd_fields();
        bus_wr(1, 8'h88);
        check("R3 hunt ignored, break set", cmd_out(), 8'h01);
        check("R3 mode unchanged by command", fmt_out(), 8'h4E);
    endtask

    task automatic t_irst();
        bus_wr(1, 8'h40);
        check("R4 reset clears command", cmd_out(), 8'h00);
        bus_wr(1, 8'hF9);
        check("R2 R4 mode after reset", fmt_out(), 8'hF9);
        check("R4 mode byte not a command", cmd_out(), 8'h00);
        bus_wr(1, 8'h22);
        check("R2 next write is command", cmd_out(), 8'h18);
        check("R2 mode kept after command", fmt_out(), 8'hF9);
    endtask

    task automatic t_irst_discard();
        logic [7:0] v; logic tk;
        err_pulse(0, 1, 0);
        bus_wr(1, 8'h7F);
        check("R4 other bits discarded", cmd_out(), 8'h00);
        bus_rd(1, v, tk);
        check("R4 error reset bit discarded", v & 8'h38, 8'h10);
        bus_wr(1, 8'h00);
        check("R9 zero codes normalized", fmt_out(), 8'h41);
        bus_wr(1, 8'h14);
        check("R3 rx enable command", cmd_out(), 8'h02);
    endtask

    task automatic t_errors();
        logic [7:0] v; logic tk;
        err_pulse(1, 0, 0);
        bus_rd(1, v, tk);
        check("R6 parity flag alone", v & 8'h38, 8'h08);
        repeat (5) @(negedge clk);
        bus_rd(1, v, tk);
        check("R6 parity flag held", v & 8'h38, 8'h08);
        err_pulse(0, 1, 1);
        bus_wr(1, 8'h04);
        bus_rd(1, v, tk);
        check("R6 flags survive command without clear", v & 8'h38, 8'h38);
        bus_wr(1, 8'h14);
        bus_rd(1, v, tk);
        check("R5 clear all flags", v & 8'h38, 8'h00);
        err_pulse(0, 1, 1);
        @(negedge clk);
        sel_i = 1; wr_i = 1; addr_ctl_i = 1; wdata_i = 8'h14; rx_par_err_i = 1;
        @(negedge clk);
        sel_i = 0; wr_i = 0; rx_par_err_i = 0;
        bus_rd(1, v, tk);
        check("R5 same-cycle error wins", v & 8'h38, 8'h08);
    endtask

    task automatic t_status();
        logic [7:0] v; logic tk;
        tx_ready_i = 0; tx_empty_i = 0; rx_ready_i = 1; rx_brk_i = 1; dsr_n_i = 0;
        bus_rd(1, v, tk);
        check("R7 R8 status layout, dsr low", v, 8'hCA);
        dsr_n_i = 1;
        bus_rd(1, v, tk);
        check("R8 dsr high reads 0", v, 8'h4A);
        check("R10 status read no take", {7'b0, tk}, 8'h00);
    endtask

    task automatic t_data();
        logic [7:0] v; logic tk;
        rx_data_i = 8'hA5;
        bus_rd(0, v, tk);
        check("R10 data read value", v, 8'hA5);
        check("R10 data read take", {7'b0, tk}, 8'h01);
        @(negedge clk);
        sel_i = 1; wr_i = 1; addr_ctl_i = 0; wdata_i = 8'h40;
        #1;
        check("R10 data write load", {7'b0, tx_load_o}, 8'h01);
        check("R10 data write byte", tx_data_o, 8'h40);
        @(negedge clk);
        sel_i = 0; wr_i = 0;
        check("R10 data write no control change", cmd_out(), 8'h02);
        @(negedge clk);
        sel_i = 0; wr_i = 1; addr_ctl_i = 1; wdata_i = 8'h40;
        @(negedge clk);
        wr_i = 0;
        check("R10 deselected write ignored", cmd_out(), 8'h02);
        rd_i = 1;
        #1 check("R10 deselected read is 0", rdata_o, 8'h00);
        rd_i = 0;
        bus_wr(1, 8'h26);
        check("R10 still in command state", cmd_out(), 8'h1A);
        check("R10 mode unchanged", fmt_out(), 8'h41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_init();
        t_cmd_fields();
        t_irst();
        t_irst_discard();
        t_errors();
        t_status();
        t_data();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule